// File: doc/BRIEF.md
# Preset Counter/Timer with Zero Detect

This block is a 16-bit down-counter for one channel of a serial communications controller. Software loads a 16-bit preset and a control byte, then issues start, stop and preset commands through a small byte-wide register port. The counter decrements on ticks from a selectable source, optionally divided by a prescaler. When the count reaches zero the block sets a sticky zero status flag, can raise an interrupt, and updates an output waveform that can be routed to a channel clock pin.

Two control bits choose what happens at zero and what the output looks like. In reload mode the counter takes the preset again on the next tick. In wrap mode it keeps counting down through all ones. The output either toggles on each zero or gives a pulse that lasts exactly one counting tick. A measurement source times a low period on the receive data line in units of four system clocks. A character source counts received characters as they enter the receive FIFO, and it flags the character that brings the count to zero so that character can carry an end-of-message mark.

Top module: `ctmr_top`

## Requirements
- R1: `zero_irq` is high exactly when the zero status flag is set, control bit 7 is 1 and `master_ie` is 1; with `master_ie` low it stays low.
- R2: With control bit 6 = 0, a tick taken while the count is 0 loads the 16-bit preset, so after T ticks from preset P the count is P - (T mod (P+1)).
- R3: With control bit 6 = 1, a tick taken while the count is 0 gives 0xFFFF, so after T ticks the count is (P - T) mod 2^16.
- R4: With control bit 5 = 0, `tmr_out` toggles on every tick that takes the count from 1 to 0; command 0x03 (load preset) and command 0x04 (load all ones) both force `tmr_out` low.
- R5: With control bit 5 = 1, `tmr_out` goes high on the tick that reaches zero and low again on the next tick, whatever the number of system clocks between the two.
- R6: Control bits [4:3] select the prescaler: 00 = 1, 01 = 16, 10 = 32, 11 = 64 source events per tick. The start command clears the prescaler phase.
- R7: Source code 3 (control bits [2:0]) measures a low period on `rxd`. A falling edge while the counter runs begins the measurement. Each fourth system clock while it is active is a tick. The rising edge takes a final tick, sets the zero status flag and stops the counter, so a low period of 4N clocks subtracts N.
- R8: Source code 6 counts `rx_char_ld` strobes. `eom_mark` is high in the same cycle as the strobe that takes the count from 1 to 0, and low for every other strobe.
- R9: Command 0x01 starts counting and command 0x02 stops it; while stopped the count does not change. Source codes 0, 1 and 2 are the system clock, `src_a` and `src_b`.
- R10: Register map: 0 control, 1 preset high, 2 preset low, 3 count high, 4 count low, 5 status (bit 0 = zero flag), 6 command. A read of address 4 returns the live low byte and captures the high byte; address 3 returns that captured byte.
- R11: The zero flag is set by every zero event and by the end of a measurement. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R12: After `rst_n` is low, every register, the count, the flag and `tmr_out` are 0, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to capture the count high byte) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| master_ie | input | 1 | Channel master interrupt enable |
| src_a | input | 1 | External count source A, one strobe per event |
| src_b | input | 1 | External count source B, one strobe per event |
| rxd | input | 1 | Receive data line, idle high |
| rx_char_ld | input | 1 | Strobe when a character moves into the receive FIFO |
| zero_irq | output | 1 | Interrupt request |
| tmr_out | output | 1 | Timer output waveform |
| eom_mark | output | 1 | End-of-message mark for the character being loaded |

## Verification
Some rules are checked on every cycle: the reload and wrap values after a tick at zero, that the output is low after either preset command, that every output pulse follows a zero event, that a stopped counter holds its value, that a zero event sets the flag, and that the interrupt stays masked when `master_ie` is low. Other behaviour only shows up across a whole scenario, so the bench scenarios cover it. That includes the count reached after a long run in each zero mode, the prescaler ratios, the captured high byte when reading the count in two parts, the result of a measurement with the counter stopping itself, and which character strobe raises the end-of-message mark.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned CTR_W = 2 * BYTE_W;
  localparam int unsigned PRE_W = 6;

  typedef enum logic [2:0] {
    SRC_SYS    = 3'd0,
    SRC_EXTA   = 3'd1,
    SRC_EXTB   = 3'd2,
    SRC_RXMEAS = 3'd3,
    SRC_NONE4  = 3'd4,
    SRC_NONE5  = 3'd5,
    SRC_CHAR   = 3'd6,
    SRC_NONE7  = 3'd7
  } src_e;

  typedef struct packed {
    logic       irq_en;
    logic       wrap;
    logic       pulse;
    logic [1:0] pre;
    src_e       src;
  } ctl_t;

  localparam logic [BYTE_W-1:0] CMD_START  = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_STOP   = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_LDPRE  = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_LDONES = 8'h04;

  // source events per tick for a prescaler select code
  function automatic int unsigned pre_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

  // count value after one tick
  function automatic logic [CTR_W-1:0] next_count(input logic [CTR_W-1:0] cur,
                                                  input logic [CTR_W-1:0] preset,
                                                  input logic wrap);
    if (cur == '0) return wrap ? '1 : preset;
    return cur - CTR_W'(1);
  endfunction
endpackage

// File: rtl/ctmr_measure.sv
module ctmr_measure #(
  parameter int unsigned MEAS_DIV = 4
)(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rxd,
  output logic meas_tick,
  output logic meas_done
);
  localparam int unsigned DIV_W = (MEAS_DIV > 1) ? $clog2(MEAS_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MEAS_DIV - 1);

  logic             rxd_q;
  logic             active;
  logic [DIV_W-1:0] div;
  logic             fall;

  assign fall      = en && !active && rxd_q && !rxd;
  assign meas_tick = en && active && (div == DIV_LAST);
  assign meas_done = en && active && rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q  <= 1'b1;
      active <= 1'b0;
      div    <= '0;
    end else begin
      rxd_q <= rxd;
      if (!en || meas_done) begin
        active <= 1'b0;
        div    <= '0;
      end else if (fall) begin
        active <= 1'b1;
        div    <= '0;
      end else if (active) begin
        div <= (div == DIV_LAST) ? '0 : div + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen
  import ctmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  src_e       src,
  input  logic [1:0] pre,
  input  logic       src_a,
  input  logic       src_b,
  input  logic       char_ld,
  input  logic       meas_tick,
  output logic       tick
);
  logic             strobe;
  logic [PRE_W-1:0] pcnt;
  logic             last;

  always_comb begin
    case (src)
      SRC_SYS:  strobe = 1'b1;
      SRC_EXTA: strobe = src_a;
      SRC_EXTB: strobe = src_b;
      SRC_CHAR: strobe = char_ld;
      default:  strobe = 1'b0;
    endcase
  end

  assign last = (pcnt == PRE_W'(pre_div(pre) - 1));
  assign tick = (src == SRC_RXMEAS) ? meas_tick : (run && strobe && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (restart)          pcnt <= '0;
    else if (run && strobe)    pcnt <= last ? '0 : pcnt + PRE_W'(1);
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic             pulse,
  input  logic             ld_preset,
  input  logic             ld_ones,
  input  logic [CTR_W-1:0] preset,
  output logic [CTR_W-1:0] cnt,
  output logic             zero_evt,
  output logic             tmr_out
);
  assign zero_evt = tick && (cnt == CTR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tmr_out <= 1'b0;
    end else begin
      if (ld_preset)    cnt <= preset;
      else if (ld_ones) cnt <= '1;
      else if (tick)    cnt <= next_count(cnt, preset, wrap);

      if (ld_preset || ld_ones) tmr_out <= 1'b0;
      else if (zero_evt)        tmr_out <= pulse ? 1'b1 : !tmr_out;
      else if (tick && pulse)   tmr_out <= 1'b0;
    end
  end
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MEAS_DIV = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              master_ie,
  input  logic              src_a,
  input  logic              src_b,
  input  logic              rxd,
  input  logic              rx_char_ld,
  output logic              zero_irq,
  output logic              tmr_out,
  output logic              eom_mark
);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PRE_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(6);

  ctl_t              ctl_q;
  logic [BYTE_W-1:0] pre_hi, pre_lo, hi_latch;
  logic              zstat, run;
  logic [CTR_W-1:0]  preset, cnt;
  logic              cmd_wr, cmd_start, cmd_stop, ld_preset, ld_ones, ld_any;
  logic              tick, zero_evt, meas_tick, meas_done, meas_en;

  assign preset    = {pre_hi, pre_lo};
  assign cmd_wr    = reg_wr && (reg_addr == A_CMD);
  assign cmd_start = cmd_wr && (reg_wdata == CMD_START);
  assign cmd_stop  = cmd_wr && (reg_wdata == CMD_STOP);
  assign ld_preset = cmd_wr && (reg_wdata == CMD_LDPRE);
  assign ld_ones   = cmd_wr && (reg_wdata == CMD_LDONES);
  assign ld_any    = ld_preset || ld_ones;
  assign meas_en   = run && (ctl_q.src == SRC_RXMEAS);

  ctmr_measure #(.MEAS_DIV(MEAS_DIV)) u_meas (
    .clk(clk), .rst_n(rst_n), .en(meas_en), .rxd(rxd),
    .meas_tick(meas_tick), .meas_done(meas_done)
  );

  ctmr_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(cmd_start),
    .src(ctl_q.src), .pre(ctl_q.pre), .src_a(src_a), .src_b(src_b),
    .char_ld(rx_char_ld), .meas_tick(meas_tick), .tick(tick)
  );

  ctmr_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(ctl_q.wrap), .pulse(ctl_q.pulse),
    .ld_preset(ld_preset), .ld_ones(ld_ones), .preset(preset),
    .cnt(cnt), .zero_evt(zero_evt), .tmr_out(tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      pre_hi   <= '0;
      pre_lo   <= '0;
      hi_latch <= '0;
      zstat    <= 1'b0;
      run      <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTL)    ctl_q  <= ctl_t'(reg_wdata);
      if (reg_wr && reg_addr == A_PRE_HI) pre_hi <= reg_wdata;
      if (reg_wr && reg_addr == A_PRE_LO) pre_lo <= reg_wdata;
      if (reg_rd && reg_addr == A_CNT_LO) hi_latch <= cnt[CTR_W-1:BYTE_W];

      if (zero_evt || meas_done)                       zstat <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) zstat <= 1'b0;

      if (meas_done)      run <= 1'b0;
      else if (cmd_start) run <= 1'b1;
      else if (cmd_stop)  run <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:    reg_rdata = ctl_q;
      A_PRE_HI: reg_rdata = pre_hi;
      A_PRE_LO: reg_rdata = pre_lo;
      A_CNT_HI: reg_rdata = hi_latch;
      A_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      A_STAT:   reg_rdata = {{(BYTE_W-1){1'b0}}, zstat};
      default:  reg_rdata = '0;
    endcase
  end

  assign zero_irq = zstat && ctl_q.irq_en && master_ie;
  assign eom_mark = zero_evt && (ctl_q.src == SRC_CHAR);
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int unsigned CW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] preset,
  input logic          wrap,
  input logic          pulse,
  input logic          ld_any,
  input logic          zero_evt,
  input logic          zstat,
  input logic          run,
  input logic          tmr_out,
  input logic          master_ie,
  input logic          zero_irq
);
  // R2
  reload_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !wrap && !ld_any) |=> (cnt == $past(preset)));

  // R3
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && wrap && !ld_any) |=> (&cnt));

  // R4
  preset_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_any |=> !tmr_out);

  // R5
  pulse_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmr_out) && pulse) |-> $past(zero_evt));

  // R9
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_any) |=> $stable(cnt));

  // R11
  zero_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> zstat);

  // R1
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_ie |-> !zero_irq);
endmodule

bind ctmr_top ctmr_chk #(.CW(ctmr_pkg::CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .preset(preset),
  .wrap(ctl_q.wrap), .pulse(ctl_q.pulse), .ld_any(ld_any), .zero_evt(zero_evt),
  .zstat(zstat), .run(run), .tmr_out(tmr_out), .master_ie(master_ie),
  .zero_irq(zero_irq)
);

// File: tb/tb_ctmr_top.sv
module tb_ctmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       master_ie = 1'b0, src_a = 1'b0, src_b = 1'b0, rxd = 1'b1, rx_char_ld = 1'b0;
  logic       zero_irq, tmr_out, eom_mark;

  int checks = 0;
  int failures = 0;

  always #2 clk = !clk;

  ctmr_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .master_ie(master_ie),
    .src_a(src_a), .src_b(src_b), .rxd(rxd), .rx_char_ld(rx_char_ld),
    .zero_irq(zero_irq), .tmr_out(tmr_out), .eom_mark(eom_mark)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [15:0] p);
    wr(3'd0, ctl);
    wr(3'd1, p[15:8]);
    wr(3'd2, p[7:0]);
    wr(3'd6, 8'h03);
    wr(3'd5, 8'h01);
  endtask

  // start, idle k negedges, stop: k+1 ticks of the system clock
  task automatic run_for(input int k);
    wr(3'd6, 8'h01);
    repeat (k) @(negedge clk);
    wr(3'd6, 8'h02);
  endtask

  task automatic read_count(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd4, lo);
    rd(3'd3, hi);
    v = {hi, lo};
  endtask

  function automatic logic [15:0] model_reload(input int p, input int t);
    return 16'(p - (t % (p + 1)));
  endfunction

  function automatic logic [15:0] model_wrap(input int p, input int t);
    return 16'((p - t) & 32'hFFFF);
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] v;
    rd(3'd0, d);  check("R12 control", 16'(d), 16'h0);
    rd(3'd1, d);  check("R12 preset high", 16'(d), 16'h0);
    read_count(v); check("R12 count", v, 16'h0);
    rd(3'd5, d);  check("R12 status", 16'(d), 16'h0);
    check("R12 tmr_out", 16'(tmr_out), 16'h0);
    check("R12 zero_irq", 16'(zero_irq), 16'h0);
  endtask

  task automatic t_reload;
    logic [15:0] v;
    logic [7:0] d;
    setup(8'h00, 16'd3);
    run_for(7);
    read_count(v); check("R2 reload count", v, model_reload(3, 8));
    rd(3'd5, d);   check("R11 flag set by zero", 16'(d), 16'h1);
    wr(3'd5, 8'h00);
    rd(3'd5, d);   check("R11 write 0 keeps flag", 16'(d), 16'h1);
    wr(3'd5, 8'h01);
    rd(3'd5, d);   check("R11 write 1 clears flag", 16'(d), 16'h0);
  endtask

  task automatic t_wrap;
    logic [15:0] v, v2;
    setup(8'h40, 16'd2);
    run_for(4);
    read_count(v); check("R3 wrap count", v, model_wrap(2, 5));
    repeat (10) @(negedge clk);
    read_count(v2); check("R9 stopped count frozen", v2, v);
  endtask

  task automatic t_latch;
    logic [7:0] lo, hi;
    logic [15:0] v;
    setup(8'h00, 16'h0105);
    wr(3'd6, 8'h01);
    repeat (2) @(negedge clk);
    rd(3'd4, lo);  check("R10 live low byte", 16'(lo), 16'h03);
    repeat (20) @(negedge clk);
    rd(3'd3, hi);  check("R10 high byte captured", 16'(hi), 16'h01);
    wr(3'd6, 8'h02);
    read_count(v); check("R10 high after later read", 16'(v[15:8]), 16'h00);
  endtask

  task automatic t_toggle;
    logic [15:0] v;
    setup(8'h00, 16'd1);
    run_for(1);
    check("R4 toggle after one zero", 16'(tmr_out), 16'h1);
    wr(3'd6, 8'h03);
    #1 check("R4 preset command clears out", 16'(tmr_out), 16'h0);
    read_count(v); check("R4 preset reloaded", v, 16'd1);
    run_for(0);
    check("R4 toggle high again", 16'(tmr_out), 16'h1);
    wr(3'd6, 8'h04);
    #1 check("R4 ones command clears out", 16'(tmr_out), 16'h0);
  endtask

  task automatic pulse_a;
    @(negedge clk); src_a = 1'b1;
    @(posedge clk); #1 src_a = 1'b0;
  endtask

  task automatic t_pulse;
    logic [15:0] v;
    setup(8'h21, 16'd1);
    wr(3'd6, 8'h01);
    pulse_a();
    repeat (5) @(negedge clk);
    check("R5 pulse held until next tick", 16'(tmr_out), 16'h1);
    pulse_a();
    #1 check("R5 pulse ends on next tick", 16'(tmr_out), 16'h0);
    wr(3'd6, 8'h02);
    read_count(v); check("R9 external source ticks", v, 16'd1);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    setup(8'h08, 16'h0010);
    run_for(31);
    read_count(v); check("R6 divide by 16", v, 16'h000E);
    setup(8'h18, 16'h0010);
    run_for(63);
    read_count(v); check("R6 divide by 64", v, 16'h000F);
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk); rxd = 1'b0;
    repeat (n) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic t_measure;
    logic [15:0] v;
    logic [7:0] d;
    setup(8'h03, 16'h0000);
    wr(3'd6, 8'h04);
    wr(3'd6, 8'h01);
    low_pulse(20);
    repeat (3) @(negedge clk);
    read_count(v); check("R7 measured count", v, 16'hFFFA);
    rd(3'd5, d);   check("R7 flag at end", 16'(d), 16'h1);
    low_pulse(8);
    repeat (3) @(negedge clk);
    read_count(v); check("R7 stopped after measure", v, 16'hFFFA);
  endtask

  task automatic t_char;
    logic [15:0] v;
    setup(8'h06, 16'd2);
    wr(3'd6, 8'h01);
    @(negedge clk); rx_char_ld = 1'b1;
    #1 check("R8 no mark first char", 16'(eom_mark), 16'h0);
    @(posedge clk); #1 rx_char_ld = 1'b0;
    @(negedge clk); rx_char_ld = 1'b1;
    #1 check("R8 mark on zero char", 16'(eom_mark), 16'h1);
    @(posedge clk); #1 rx_char_ld = 1'b0;
    wr(3'd6, 8'h02);
    read_count(v); check("R8 char count", v, 16'h0);
  endtask

  task automatic t_irq;
    master_ie = 1'b0;
    wr(3'd0, 8'h86);
    #1 check("R1 masked by master", 16'(zero_irq), 16'h0);
    @(negedge clk); master_ie = 1'b1;
    #1 check("R1 irq asserted", 16'(zero_irq), 16'h1);
    wr(3'd0, 8'h06);
    #1 check("R1 control bit 7 off", 16'(zero_irq), 16'h0);
    wr(3'd0, 8'h86);
    wr(3'd5, 8'h01);
    #1 check("R1 cleared flag drops irq", 16'(zero_irq), 16'h0);
    master_ie = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_reload();
    t_wrap();
    t_latch();
    t_toggle();
    t_pulse();
    t_prescale();
    t_measure();
    t_char();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule